// File: doc/BRIEF.md
# Snooping MOSI Line Coherence Controller

This block keeps a private cache coherent on a system where address requests travel on a totally ordered broadcast bus and data moves on a separate unordered network. It holds the MOSI state of a small number of lines (a line index doubles as the line address) together with one data word per line. It also has a single transaction buffer that carries one outstanding miss, upgrade or writeback.

Three inputs feed it: processor requests, snooped address messages (which include this node's own requests when the bus orders them) and incoming data messages. The block emits address requests, data responses to other nodes and a completion strobe per demand access. Because the data network is unordered, a miss keeps two facts apart: that its own request has been ordered on the bus, and that its data has arrived. Either may come first. While a write miss waits for data, any node that snoops a read or write of that line is recorded. Once the data arrives, that node is sent the block.

All three inputs use valid/ready. Only one event is taken per cycle. Data always has priority, so `dat_ready` is tied high. `snp_ready` is low while data is offered. `req_ready` is low while a snoop or data message is offered, and also while the request has to stall. A request that stalls stays at the input untouched. All outputs are registered single-cycle pulses that cannot be back-pressured, and each appears one clock after the event that causes it is accepted.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: After reset every line reads state NP with permission 0, no output strobe is active and `proto_err` is 0.
- R2: A processor request to a line in NP or I allocates the transaction buffer. A load (op 0) issues type 0 (read), an instruction fetch (op 1) issues type 1 (instruction read), a store (op 2) issues type 2 (exclusive read). The line moves to the read or write wait state, and the request pulse appears on the `areq` port one cycle after the request is accepted.
- R3: A pending miss completes only once it has seen both its own ordered request (a snoop whose `snp_src` equals `NODE_ID`) and the data, in either order. Completion writes the data into the line, pulses `done_valid` with that data (`done_store`=0 for a read, 1 for a write) and leaves the line in S or M. A demand load or fetch that hits S, O or M completes at once, and so does a store that hits M.
- R4: On another node's read (type 0 or 1), M sends its data to that node and becomes O, O sends its data and stays O, and S stays S silently. On another node's exclusive read (type 2), M and O send their data and become I, and S becomes I with no output.
- R5: In a write wait state that has already seen its own request, each later foreign snoop adds the requestor to a forward set. A foreign read moves the line to a forward variant and a foreign exclusive read moves it to an invalidate variant. When data arrives, the store completes, one response goes to every recorded node (`rsp_dest` is a bit mask indexed by node id), and the line ends in O after reads only and in I otherwise.
- R6: A read miss that has seen its own request and then a foreign exclusive read still completes the load when its data arrives, and the line ends in I.
- R7: Replacing a line (op 5) in M or O issues type 3 (writeback) carrying the line data, copies the data into the transaction buffer and enters a writeback state. Replacing a line in S or I returns it to NP with no output.
- R8: During a writeback, foreign reads and exclusive reads are answered from the transaction buffer, and a foreign exclusive read moves the line into the lost-ownership writeback state. When the block sees its own writeback ordered, the line goes to I and the buffer is released.
- R9: A store to O issues an exclusive read. When that request is ordered, the line goes straight to M and the store completes with the line data. A foreign exclusive read seen before then sends the data and drops to the write-miss wait state. A store to S issues an exclusive read, and a foreign exclusive read seen before completion downgrades that upgrade to a plain write miss.
- R10: A load prefetch (op 3) or store prefetch (op 4) that misses goes through the same sequence as a demand access, but produces no completion strobe. A prefetch that hits a stable state with enough permission is consumed with no output and no state change.
- R11: A demand request or replacement to a line in a transient state, and any request that needs the transaction buffer while the buffer is in use, holds `req_ready` low. The stalled request has no effect. Data has priority over snoops, and snoops have priority over processor requests.
- R12: A foreign writeback snoop (type 3) has no effect in any state.
- R13: `look_perm` for the line selected by `look_addr` is 0 (invalid) in NP, I, the modified writeback state and the lost-ownership writeback state. It is 1 (read) in S and O, 2 (read-write) in M and 3 (busy) in every other transient state.
- R14: An event that the current state does not handle leaves the state unchanged and sets `proto_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request offered |
| req_ready | output | 1 | Processor request accepted this cycle |
| req_op | input | 3 | 0 load, 1 fetch, 2 store, 3 load prefetch, 4 store prefetch, 5 replacement |
| req_addr | input | AW | Line index of the request |
| snp_valid | input | 1 | Snooped address message offered |
| snp_ready | output | 1 | Snooped message accepted |
| snp_type | input | 2 | 0 read, 1 instruction read, 2 exclusive read, 3 writeback |
| snp_src | input | NIDW | Requesting node id |
| snp_addr | input | AW | Line index of the snooped request |
| dat_valid | input | 1 | Data message offered |
| dat_ready | output | 1 | Data message accepted (always 1) |
| dat_addr | input | AW | Line index of the data |
| dat_data | input | DW | Data word |
| areq_valid | output | 1 | Address request pulse |
| areq_type | output | 2 | Request type, encoded as `snp_type` |
| areq_addr | output | AW | Line index of the request |
| areq_data | output | DW | Line data (meaningful for writebacks) |
| rsp_valid | output | 1 | Data response pulse |
| rsp_dest | output | NNODES | Destination node mask |
| rsp_addr | output | AW | Line index of the response |
| rsp_data | output | DW | Response data |
| done_valid | output | 1 | Demand access completion pulse |
| done_store | output | 1 | 1 for a store completion, 0 for a read |
| done_addr | output | AW | Completed line |
| done_data | output | DW | Line data at completion |
| look_addr | input | AW | Line to observe |
| look_state | output | 5 | State code of that line |
| look_perm | output | 2 | Access permission of that line |
| proto_err | output | 1 | Sticky unexpected-event flag |

## Verification
A wrong transient state mostly stays hidden until the next ordered request or data message for that line. At that point it appears in the very next cycle as a missing, extra or misaddressed pulse on `done`, `rsp` or `areq`. For example, a lost forward record turns into a missing bit of `rsp_dest` only when the data finally arrives. To shorten that delay, the scoreboard checks the exact state code and permission on the observe port after every step. It also treats any pulse it did not expect, such as a completion after a prefetch, as an error on the cycle the pulse occurs.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [4:0] {
    C_NP, C_INV, C_SHD, C_OWN, C_MOD,
    C_RD_AD, C_WR_AD, C_UP_AD, C_OU_A,
    C_RD_A, C_WR_A, C_UP_A,
    C_MW_A, C_OW_A, C_LW_A,
    C_RD_D, C_RD_DI, C_WR_D, C_WR_DF, C_WR_DI, C_WR_DFI, C_UP_D, C_UP_DF
  } cst_e;

  typedef enum logic [1:0] {BT_RD = 2'd0, BT_RDI = 2'd1, BT_RDX = 2'd2, BT_WB = 2'd3} bus_e;

  typedef enum logic [4:0] {
    EV_NONE, EV_LD, EV_IF, EV_ST, EV_LDPF, EV_STPF, EV_REPL, EV_BADOP,
    EV_OGETS, EV_OGETI, EV_OGETX, EV_OPUTX,
    EV_XGETS, EV_XGETI, EV_XGETX, EV_XPUTX, EV_DATA
  } ev_e;

  typedef struct packed {
    logic stall;
    logic err;
    logic issue;
    bus_e ity;
    logic alloc;
    logic setpf;
    logic save;
    logic wline;
    logic cptbe;
    logic done_ld;
    logic done_st;
    logic rsp_line;
    logic rsp_tbe;
    logic rec;
    logic fwd;
    logic free_tbe;
    cst_e nxt;
  } act_t;

  function automatic logic [1:0] perm_of(cst_e s);
    case (s)
      C_NP, C_INV, C_MW_A, C_LW_A: perm_of = 2'd0;
      C_SHD, C_OWN:                perm_of = 2'd1;
      C_MOD:                       perm_of = 2'd2;
      default:                     perm_of = 2'd3;
    endcase
  endfunction

  function automatic logic is_trans(cst_e s);
    is_trans = !(s inside {C_NP, C_INV, C_SHD, C_OWN, C_MOD});
  endfunction
endpackage

// File: rtl/coh_evt_sel.sv
module coh_evt_sel
  import coh_pkg::*;
#(
  parameter int NNODES  = 4,
  parameter int AW      = 2,
  parameter int NIDW    = 2,
  parameter int NODE_ID = 0
) (
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic            snp_valid,
  input  logic [1:0]      snp_type,
  input  logic [NIDW-1:0] snp_src,
  input  logic [AW-1:0]   snp_addr,
  input  logic            dat_valid,
  input  logic [AW-1:0]   dat_addr,
  output ev_e             ev,
  output logic [AW-1:0]   ev_addr
);
  logic own;
  assign own = (snp_src == NIDW'(NODE_ID));

  always_comb begin
    ev = EV_NONE;
    ev_addr = req_addr;
    if (dat_valid) begin
      ev = EV_DATA;
      ev_addr = dat_addr;
    end else if (snp_valid) begin
      ev_addr = snp_addr;
      case (snp_type)
        2'd0:    ev = own ? EV_OGETS : EV_XGETS;
        2'd1:    ev = own ? EV_OGETI : EV_XGETI;
        2'd2:    ev = own ? EV_OGETX : EV_XGETX;
        default: ev = own ? EV_OPUTX : EV_XPUTX;
      endcase
    end else if (req_valid) begin
      case (req_op)
        3'd0:    ev = EV_LD;
        3'd1:    ev = EV_IF;
        3'd2:    ev = EV_ST;
        3'd3:    ev = EV_LDPF;
        3'd4:    ev = EV_STPF;
        3'd5:    ev = EV_REPL;
        default: ev = EV_BADOP;
      endcase
    end
  end
endmodule

// File: rtl/coh_next.sv
module coh_next
  import coh_pkg::*;
(
  input  cst_e st,
  input  ev_e  ev,
  input  logic tbe_busy,
  output act_t a
);
  logic rd_own, rd_oth, oth, dem;

  always_comb begin
    rd_own = ev inside {EV_OGETS, EV_OGETI};
    rd_oth = ev inside {EV_XGETS, EV_XGETI};
    oth    = rd_oth || (ev == EV_XGETX);
    dem    = ev inside {EV_LD, EV_IF, EV_ST, EV_REPL};
    a      = '0;
    a.ity  = BT_RD;
    a.nxt  = st;
    if (ev == EV_NONE || ev == EV_XPUTX) begin
      a.nxt = st;
    end else if (is_trans(st) && dem) begin
      a.stall = 1'b1;
    end else if (is_trans(st) && ev == EV_LDPF) begin
      a.stall = st inside {C_RD_DI, C_WR_DI, C_WR_DFI, C_MW_A, C_OW_A, C_LW_A};
    end else if (is_trans(st) && ev == EV_STPF) begin
      a.stall = !(st inside {C_WR_AD, C_UP_AD, C_OU_A, C_WR_A, C_UP_A, C_WR_D, C_UP_D});
    end else begin
      case (st)
        C_NP, C_INV: begin
          if (ev inside {EV_LD, EV_IF, EV_LDPF}) begin
            a.issue = 1'b1; a.alloc = 1'b1; a.nxt = C_RD_AD;
            a.ity = (ev == EV_IF) ? BT_RDI : BT_RD;
            a.setpf = (ev == EV_LDPF);
          end else if (ev inside {EV_ST, EV_STPF}) begin
            a.issue = 1'b1; a.alloc = 1'b1; a.nxt = C_WR_AD; a.ity = BT_RDX;
            a.setpf = (ev == EV_STPF);
          end else if (ev == EV_REPL && st == C_INV) a.nxt = C_NP;
          else if (!oth) a.err = 1'b1;
        end
        C_SHD: begin
          if (ev inside {EV_LD, EV_IF}) a.done_ld = 1'b1;
          else if (ev == EV_ST) begin
            a.issue = 1'b1; a.alloc = 1'b1; a.ity = BT_RDX; a.nxt = C_UP_AD;
          end else if (ev == EV_STPF) begin
            a.issue = 1'b1; a.alloc = 1'b1; a.ity = BT_RDX; a.setpf = 1'b1; a.nxt = C_WR_AD;
          end else if (ev == EV_REPL) a.nxt = C_NP;
          else if (ev == EV_XGETX) a.nxt = C_INV;
          else if (!(rd_oth || ev == EV_LDPF)) a.err = 1'b1;
        end
        C_OWN, C_MOD: begin
          if (ev inside {EV_LD, EV_IF}) a.done_ld = 1'b1;
          else if (ev inside {EV_ST, EV_STPF} && st == C_OWN) begin
            a.issue = 1'b1; a.alloc = 1'b1; a.ity = BT_RDX; a.nxt = C_OU_A;
            a.setpf = (ev == EV_STPF);
          end else if (ev == EV_ST) a.done_st = 1'b1;
          else if (ev == EV_REPL) begin
            a.issue = 1'b1; a.alloc = 1'b1; a.ity = BT_WB; a.cptbe = 1'b1;
            a.nxt = (st == C_MOD) ? C_MW_A : C_OW_A;
          end else if (rd_oth) begin
            a.rsp_line = 1'b1; a.nxt = C_OWN;
          end else if (ev == EV_XGETX) begin
            a.rsp_line = 1'b1; a.nxt = C_INV;
          end else if (!(ev inside {EV_LDPF, EV_STPF})) a.err = 1'b1;
        end
        C_RD_AD, C_WR_AD, C_UP_AD, C_OU_A: begin
          if (ev == EV_DATA && st != C_OU_A) begin
            a.save = 1'b1;
            a.nxt = (st == C_RD_AD) ? C_RD_A : (st == C_WR_AD) ? C_WR_A : C_UP_A;
          end else if (ev == EV_DATA) begin
            a.save = 1'b1; a.nxt = C_WR_A;
          end else if (rd_own && st == C_RD_AD) a.nxt = C_RD_D;
          else if (ev == EV_OGETX && st == C_WR_AD) a.nxt = C_WR_D;
          else if (ev == EV_OGETX && st == C_UP_AD) a.nxt = C_UP_D;
          else if (ev == EV_OGETX && st == C_OU_A) begin
            a.done_st = 1'b1; a.free_tbe = 1'b1; a.nxt = C_MOD;
          end else if (oth && st == C_OU_A) begin
            a.rsp_line = 1'b1;
            if (ev == EV_XGETX) a.nxt = C_WR_AD;
          end else if (ev == EV_XGETX && st == C_UP_AD) a.nxt = C_WR_AD;
          else if (!oth) a.err = 1'b1;
        end
        C_RD_A, C_WR_A, C_UP_A: begin
          if ((rd_own && st == C_RD_A) || (ev == EV_OGETX && st != C_RD_A)) begin
            a.wline = 1'b1; a.free_tbe = 1'b1;
            a.done_ld = (st == C_RD_A); a.done_st = (st != C_RD_A);
            a.nxt = (st == C_RD_A) ? C_SHD : C_MOD;
          end else if (ev == EV_XGETX && st == C_UP_A) a.nxt = C_WR_A;
          else if (!oth) a.err = 1'b1;
        end
        C_MW_A, C_OW_A, C_LW_A: begin
          if (ev == EV_OPUTX) begin
            a.free_tbe = 1'b1; a.nxt = C_INV;
          end else if (oth && st != C_LW_A) begin
            a.rsp_tbe = 1'b1;
            if (ev == EV_XGETX) a.nxt = C_LW_A;
          end else if (!oth) a.err = 1'b1;
        end
        C_RD_D, C_RD_DI: begin
          if (ev == EV_DATA) begin
            a.wline = 1'b1; a.done_ld = 1'b1; a.free_tbe = 1'b1;
            a.nxt = (st == C_RD_D) ? C_SHD : C_INV;
          end else if (ev == EV_XGETX) a.nxt = C_RD_DI;
          else if (!oth) a.err = 1'b1;
        end
        default: begin
          if (ev == EV_DATA) begin
            a.wline = 1'b1; a.done_st = 1'b1; a.free_tbe = 1'b1;
            a.fwd = !(st inside {C_WR_D, C_UP_D});
            a.nxt = (st inside {C_WR_D, C_UP_D}) ? C_MOD :
                    (st inside {C_WR_DF, C_UP_DF}) ? C_OWN : C_INV;
          end else if (oth && st inside {C_WR_D, C_UP_D}) begin
            a.rec = 1'b1;
            a.nxt = rd_oth ? ((st == C_WR_D) ? C_WR_DF : C_UP_DF) : C_WR_DI;
          end else if (oth && st inside {C_WR_DF, C_UP_DF}) begin
            a.rec = 1'b1;
            if (ev == EV_XGETX) a.nxt = C_WR_DFI;
          end else if (!oth) a.err = 1'b1;
        end
      endcase
      if (a.alloc && tbe_busy) begin
        a = '0; a.ity = BT_RD; a.nxt = st; a.stall = 1'b1;
      end
    end
  end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int DW     = 16,
  localparam int AW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output cst_e              rd_st,
  output logic [DW-1:0]     rd_d,
  input  logic [AW-1:0]     lk_addr,
  output cst_e              lk_st,
  input  logic              we_st,
  input  cst_e              st_w,
  input  logic              we_d,
  input  logic [DW-1:0]     d_w,
  output logic [NLINES-1:0] busy_mask
);
  cst_e          st_q [NLINES];
  logic [DW-1:0] d_q  [NLINES];

  assign rd_st = st_q[rd_addr];
  assign rd_d  = d_q[rd_addr];
  assign lk_st = st_q[lk_addr];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign busy_mask[i] = is_trans(st_q[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= C_NP;
        d_q[i]  <= '0;
      end else if (rd_addr == AW'(i)) begin
        if (we_st) st_q[i] <= st_w;
        if (we_d)  d_q[i]  <= d_w;
      end
    end
  end
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int NLINES  = 4,
  parameter int NNODES  = 4,
  parameter int DW      = 16,
  parameter int NODE_ID = 0,
  localparam int AW     = $clog2(NLINES),
  localparam int NIDW   = $clog2(NNODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [1:0]        snp_type,
  input  logic [NIDW-1:0]   snp_src,
  input  logic [AW-1:0]     snp_addr,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [AW-1:0]     dat_addr,
  input  logic [DW-1:0]     dat_data,
  output logic              areq_valid,
  output logic [1:0]        areq_type,
  output logic [AW-1:0]     areq_addr,
  output logic [DW-1:0]     areq_data,
  output logic              rsp_valid,
  output logic [NNODES-1:0] rsp_dest,
  output logic [AW-1:0]     rsp_addr,
  output logic [DW-1:0]     rsp_data,
  output logic              done_valid,
  output logic              done_store,
  output logic [AW-1:0]     done_addr,
  output logic [DW-1:0]     done_data,
  input  logic [AW-1:0]     look_addr,
  output logic [4:0]        look_state,
  output logic [1:0]        look_perm,
  output logic              proto_err
);
  ev_e               ev;
  logic [AW-1:0]     ev_addr;
  cst_e              cur_st, lk_st;
  logic [DW-1:0]     line_d, wdata;
  act_t              act;
  logic              fire, use_pf;
  logic [NLINES-1:0] busy_mask;

  logic              tbe_valid, tbe_pf;
  logic [AW-1:0]     tbe_addr;
  logic [DW-1:0]     tbe_data;
  logic [NNODES-1:0] tbe_fwd;

  coh_evt_sel #(.NNODES(NNODES), .AW(AW), .NIDW(NIDW), .NODE_ID(NODE_ID)) u_sel (
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_src(snp_src), .snp_addr(snp_addr),
    .dat_valid(dat_valid), .dat_addr(dat_addr), .ev(ev), .ev_addr(ev_addr));

  coh_next u_next (.st(cur_st), .ev(ev), .tbe_busy(tbe_valid), .a(act));

  coh_line_store #(.NLINES(NLINES), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(ev_addr), .rd_st(cur_st), .rd_d(line_d),
    .lk_addr(look_addr), .lk_st(lk_st), .we_st(fire), .st_w(act.nxt),
    .we_d(fire && act.wline), .d_w(wdata), .busy_mask(busy_mask));

  assign fire       = (ev != EV_NONE) && !act.stall;
  assign dat_ready  = 1'b1;
  assign snp_ready  = !dat_valid;
  assign req_ready  = !dat_valid && !snp_valid && !act.stall;
  assign wdata      = (ev == EV_DATA) ? dat_data : tbe_data;
  assign use_pf     = tbe_valid && tbe_pf && (tbe_addr == ev_addr);
  assign look_state = lk_st;
  assign look_perm  = perm_of(lk_st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbe_valid <= 1'b0; tbe_pf <= 1'b0; tbe_addr <= '0; tbe_data <= '0; tbe_fwd <= '0;
      areq_valid <= 1'b0; areq_type <= '0; areq_addr <= '0; areq_data <= '0;
      rsp_valid <= 1'b0; rsp_dest <= '0; rsp_addr <= '0; rsp_data <= '0;
      done_valid <= 1'b0; done_store <= 1'b0; done_addr <= '0; done_data <= '0;
      proto_err <= 1'b0;
    end else begin
      areq_valid <= fire && act.issue;
      rsp_valid  <= fire && (act.rsp_line || act.rsp_tbe || act.fwd);
      done_valid <= fire && (act.done_ld || act.done_st) && !use_pf;
      if (fire && act.err) proto_err <= 1'b1;
      if (fire && act.issue) begin
        areq_type <= act.ity;
        areq_addr <= ev_addr;
        areq_data <= line_d;
      end
      if (fire && (act.rsp_line || act.rsp_tbe || act.fwd)) begin
        rsp_addr <= ev_addr;
        rsp_dest <= act.fwd ? tbe_fwd : (NNODES'(1) << snp_src);
        rsp_data <= act.rsp_tbe ? tbe_data : act.fwd ? wdata : line_d;
      end
      if (fire && (act.done_ld || act.done_st)) begin
        done_store <= act.done_st;
        done_addr  <= ev_addr;
        done_data  <= act.wline ? wdata : line_d;
      end
      if (fire) begin
        if (act.alloc) begin
          tbe_valid <= 1'b1;
          tbe_addr  <= ev_addr;
          tbe_pf    <= act.setpf;
          tbe_fwd   <= '0;
          if (act.cptbe) tbe_data <= line_d;
        end
        if (act.save) tbe_data <= dat_data;
        if (act.rec) tbe_fwd <= tbe_fwd | (NNODES'(1) << snp_src);
        if (act.free_tbe) tbe_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/coh_snoop_chk.sv
module coh_snoop_chk #(
  parameter int NLINES  = 4,
  parameter int NNODES  = 4,
  parameter int NODE_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              snp_valid,
  input logic              dat_valid,
  input logic              areq_valid,
  input logic              tbe_valid,
  input logic              rsp_valid,
  input logic [NNODES-1:0] rsp_dest,
  input logic              proto_err,
  input logic [NLINES-1:0] busy_mask
);
  AST_INPUT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid || dat_valid) |-> !req_ready); // R11
  AST_ONE_TRANSACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy_mask) <= 1); // R11
  AST_ISSUE_HOLDS_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    areq_valid |-> tbe_valid); // R2
  AST_RSP_DEST_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_dest != '0 && !rsp_dest[NODE_ID])); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(proto_err) |-> proto_err); // R14
endmodule

bind coh_snoop_ctrl coh_snoop_chk #(.NLINES(NLINES), .NNODES(NNODES), .NODE_ID(NODE_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .snp_valid(snp_valid),
  .dat_valid(dat_valid), .areq_valid(areq_valid), .tbe_valid(tbe_valid),
  .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .proto_err(proto_err),
  .busy_mask(busy_mask));

// File: tb/tb_coh_snoop_ctrl.sv
module tb_coh_snoop_ctrl;
  import coh_pkg::*;
  localparam int NLINES = 4, NNODES = 4, DW = 16, AW = 2, NIDW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, snp_valid = 0, dat_valid = 0;
  logic [2:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, snp_addr = 0, dat_addr = 0, look_addr = 0;
  logic [1:0] snp_type = 0;
  logic [NIDW-1:0] snp_src = 0;
  logic [DW-1:0] dat_data = 0;
  logic req_ready, snp_ready, dat_ready, areq_valid, rsp_valid, done_valid, done_store, proto_err;
  logic [1:0] areq_type, look_perm;
  logic [AW-1:0] areq_addr, rsp_addr, done_addr;
  logic [DW-1:0] areq_data, rsp_data, done_data;
  logic [NNODES-1:0] rsp_dest;
  logic [4:0] look_state;

  int errors = 0, checks = 0;
  logic [31:0] qa[$], qr[$], qd[$];
  string ta[$], tr[$], td[$];

  always #4 clk = ~clk;

  coh_snoop_ctrl #(.NLINES(NLINES), .NNODES(NNODES), .DW(DW), .NODE_ID(0)) dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ka(input logic [1:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {12'd0, t, a, (t == 2'd3) ? d : 16'd0};
  endfunction

  task automatic exp_a(input logic [1:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    qa.push_back(ka(t, a, d)); ta.push_back(tag);
  endtask
  task automatic exp_r(input logic [3:0] m, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    qr.push_back({10'd0, m, a, d}); tr.push_back(tag);
  endtask
  task automatic exp_d(input logic s, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    qd.push_back({13'd0, s, a, d}); td.push_back(tag);
  endtask

  // Monitor: pops the scoreboard queues as result pulses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && areq_valid) begin
        if (qa.size() == 0) chk(0, "R2", "unexpected areq", {12'd0, areq_type, areq_addr, areq_data}, 0);
        else begin
          logic [31:0] e; string t;
          e = qa.pop_front(); t = ta.pop_front();
          chk(ka(areq_type, areq_addr, areq_data) == e, t, "areq", ka(areq_type, areq_addr, areq_data), e);
        end
      end
      if (rst_n && rsp_valid) begin
        if (qr.size() == 0) chk(0, "R4", "unexpected rsp", {10'd0, rsp_dest, rsp_addr, rsp_data}, 0);
        else begin
          logic [31:0] e; string t;
          e = qr.pop_front(); t = tr.pop_front();
          chk({10'd0, rsp_dest, rsp_addr, rsp_data} == e, t, "rsp", {10'd0, rsp_dest, rsp_addr, rsp_data}, e);
        end
      end
      if (rst_n && done_valid) begin
        if (qd.size() == 0) chk(0, "R10", "unexpected done", {13'd0, done_store, done_addr, done_data}, 0);
        else begin
          logic [31:0] e; string t;
          e = qd.pop_front(); t = td.pop_front();
          chk({13'd0, done_store, done_addr, done_data} == e, t, "done", {13'd0, done_store, done_addr, done_data}, e);
        end
      end
    end
  end

  task automatic proc(input logic [2:0] op, input logic [AW-1:0] a, input string tag);
    @(negedge clk); req_valid = 1; req_op = op; req_addr = a;
    #1 chk(req_ready == 1'b1, tag, "req_ready", {31'd0, req_ready}, 1);
    @(negedge clk); req_valid = 0;
  endtask
  task automatic stall(input logic [2:0] op, input logic [AW-1:0] a, input string tag);
    @(negedge clk); req_valid = 1; req_op = op; req_addr = a;
    #1 chk(req_ready == 1'b0, tag, "stall ready", {31'd0, req_ready}, 0);
    req_valid = 0;
  endtask
  task automatic snoop(input logic [1:0] t, input logic [NIDW-1:0] s, input logic [AW-1:0] a);
    @(negedge clk); snp_valid = 1; snp_type = t; snp_src = s; snp_addr = a;
    @(negedge clk); snp_valid = 0;
  endtask
  task automatic data(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); dat_valid = 1; dat_addr = a; dat_data = d;
    @(negedge clk); dat_valid = 0;
  endtask
  task automatic look(input logic [AW-1:0] a, input cst_e s, input logic [1:0] p, input string tag);
    @(negedge clk); look_addr = a;
    #1 chk(look_state == 5'(s), tag, "state", {27'd0, look_state}, {27'd0, 5'(s)});
    chk(look_perm == p, tag, "perm", {30'd0, look_perm}, {30'd0, p});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < NLINES; i++) look(AW'(i), C_NP, 2'd0, "R1");
    chk(!areq_valid && !rsp_valid && !done_valid && !proto_err, "R1", "idle outputs",
        {28'd0, areq_valid, rsp_valid, done_valid, proto_err}, 0);
    // R2/R3 load miss, own request first then data
    exp_a(2'd0, 1, 0, "R2"); proc(3'd0, 1, "R2"); look(1, C_RD_AD, 2'd3, "R2");
    snoop(2'd0, 0, 1); look(1, C_RD_D, 2'd3, "R3");
    exp_d(0, 1, 16'h1111, "R3"); data(1, 16'h1111); look(1, C_SHD, 2'd1, "R13");
    // R3 fetch miss, data first then own request
    exp_a(2'd1, 2, 0, "R2"); proc(3'd1, 2, "R2");
    data(2, 16'h2222); look(2, C_RD_A, 2'd3, "R3");
    exp_d(0, 2, 16'h2222, "R3"); snoop(2'd1, 0, 2); look(2, C_SHD, 2'd1, "R3");
    exp_d(0, 1, 16'h1111, "R3"); proc(3'd0, 1, "R3");
    // R5 write miss with forwarding
    exp_a(2'd2, 3, 0, "R2"); proc(3'd2, 3, "R2");
    snoop(2'd2, 0, 3); look(3, C_WR_D, 2'd3, "R5");
    snoop(2'd0, 2, 3); look(3, C_WR_DF, 2'd3, "R5");
    snoop(2'd1, 3, 3); snoop(2'd2, 1, 3); look(3, C_WR_DFI, 2'd3, "R5");
    exp_d(1, 3, 16'h3333, "R5"); exp_r(4'b1110, 3, 16'h3333, "R5");
    data(3, 16'h3333); look(3, C_INV, 2'd0, "R5");
    // R9 upgrade from S downgraded; R11 stalls
    exp_a(2'd2, 1, 0, "R9"); proc(3'd2, 1, "R9"); look(1, C_UP_AD, 2'd3, "R9");
    snoop(2'd2, 2, 1); look(1, C_WR_AD, 2'd3, "R9");
    data(1, 16'h4444); look(1, C_WR_A, 2'd3, "R3");
    stall(3'd0, 1, "R11"); stall(3'd0, 0, "R11"); look(0, C_NP, 2'd0, "R11");
    exp_d(1, 1, 16'h4444, "R3"); snoop(2'd2, 0, 1); look(1, C_MOD, 2'd2, "R13");
    // R4 foreign read on M
    exp_r(4'b0010, 1, 16'h4444, "R4"); snoop(2'd0, 1, 1); look(1, C_OWN, 2'd1, "R4");
    // R12 foreign writeback ignored
    snoop(2'd3, 2, 1); look(1, C_OWN, 2'd1, "R12");
    // R7/R8 writeback from O
    exp_a(2'd3, 1, 16'h4444, "R7"); proc(3'd5, 1, "R7"); look(1, C_OW_A, 2'd3, "R7");
    exp_r(4'b1000, 1, 16'h4444, "R8"); snoop(2'd2, 3, 1); look(1, C_LW_A, 2'd0, "R8");
    snoop(2'd3, 0, 1); look(1, C_INV, 2'd0, "R8");
    // R10 load prefetch: no completion
    exp_a(2'd0, 0, 0, "R10"); proc(3'd3, 0, "R10");
    snoop(2'd0, 0, 0); data(0, 16'h5555); look(0, C_SHD, 2'd1, "R10");
    proc(3'd3, 0, "R10"); look(0, C_SHD, 2'd1, "R10");
    // R11 snoop beats request; R4 silent invalidation of S
    @(negedge clk); snp_valid = 1; snp_type = 2'd2; snp_src = 1; snp_addr = 0;
    req_valid = 1; req_op = 3'd0; req_addr = 0;
    #1 chk(req_ready == 1'b0, "R11", "ready under snoop", {31'd0, req_ready}, 0);
    @(negedge clk); snp_valid = 0; req_valid = 0;
    look(0, C_INV, 2'd0, "R4");
    // R9 upgrade from S with forward, then store to O
    exp_a(2'd2, 2, 0, "R9"); proc(3'd2, 2, "R9");
    snoop(2'd2, 0, 2); snoop(2'd0, 1, 2); look(2, C_UP_DF, 2'd3, "R5");
    exp_d(1, 2, 16'h6666, "R5"); exp_r(4'b0010, 2, 16'h6666, "R5");
    data(2, 16'h6666); look(2, C_OWN, 2'd1, "R5");
    exp_a(2'd2, 2, 0, "R9"); proc(3'd2, 2, "R9"); look(2, C_OU_A, 2'd3, "R9");
    exp_d(1, 2, 16'h6666, "R9"); snoop(2'd2, 0, 2); look(2, C_MOD, 2'd2, "R9");
    // R6 read miss invalidated before data
    exp_a(2'd0, 3, 0, "R6"); proc(3'd0, 3, "R6");
    snoop(2'd0, 0, 3); snoop(2'd2, 2, 3); look(3, C_RD_DI, 2'd3, "R6");
    exp_d(0, 3, 16'h7777, "R6"); data(3, 16'h7777); look(3, C_INV, 2'd0, "R6");
    // R10 store prefetch: no completion
    exp_a(2'd2, 1, 0, "R10"); proc(3'd4, 1, "R10");
    snoop(2'd2, 0, 1); data(1, 16'h8888); look(1, C_MOD, 2'd2, "R10");
    // R7 replace I; R14 error
    proc(3'd5, 0, "R7"); look(0, C_NP, 2'd0, "R7");
    chk(proto_err == 1'b0, "R14", "no error yet", {31'd0, proto_err}, 0);
    data(0, 16'h9999); look(0, C_NP, 2'd0, "R14");
    repeat (2) @(negedge clk);
    chk(proto_err == 1'b1, "R14", "sticky error", {31'd0, proto_err}, 1);
    chk(qa.size() + qr.size() + qd.size() == 0, "R3", "pending expected pulses",
        32'(qa.size() + qr.size() + qd.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule